// File: doc/BRIEF.md
# Board Control and Parity Capture

This block is the host-visible control and status port of a network interface board. A single 16-bit control/status word lets the host hold the network controller in reset, take the link out of loopback, pulse the controller's channel-attention line, and turn the two interrupt sources on or off. The same word also shows two things the host cannot write: the live controller interrupt flag and a sticky parity-error flag. Its low four bits return a strapped RAM base-address field, and two further bits enable the expansion bus and select the large RAM option.

When the memory subsystem reports a parity error with a one-cycle strobe, the block records three things: which side caused the access, which byte lane failed, and the 20-bit failing address. The address is split into a high nibble, held in the parity control word, and a low 16-bit word. The record and the flag stay frozen until the host writes the acknowledge bit. A single interrupt line combines the controller interrupt and the parity error, each gated by its own enable.

Registers are selected by a 2-bit index. Index 0 is control/status, index 1 is parity control, index 2 is the low failing address, and index 3 reads as zero. Writes take effect at the clock edge. Read data is a combinational view of the registered state.

Top module: `brdctl_top`

## Requirements
- R1: After synchronous reset all control bits, the parity flag and the captured fields are zero and `irq_o` is low. A status read then returns only the strap nibble in bits 3:0 and the controller interrupt input in bit 8.
- R2: Writing index 0 stores bits 15 (controller reset), 14 (on-air), 12 (interrupt enable), 11 (parity interrupt enable), 5 (expansion bus) and 4 (large RAM). Each reads back at the same position and drives its output (`ctl_reset_o`, `on_air_o`, `xbus_en_o`, `big_ram_o`) from the edge of the write.
- R3: `ctl_attn_o` follows status bit 13. It rises with a write that sets the bit and falls with a later write that clears it.
- R4: Status bits 9 (parity flag), 8 (controller interrupt input) and 3:0 (strap) are read-only, and writes to them have no effect. Bits 10, 7 and 6 of the status word read as zero.
- R5: A parity strobe while the flag is clear sets status bit 9 and captures the failing address and two attributes. The error source goes to parity-control bit 7, the byte lane to bit 6 and address bits 19:16 to bits 3:0. Address bits 15:0 go to index 2.
- R6: While the flag is set and no acknowledge is written, further strobes change neither the flag nor any captured field.
- R7: Writing index 1 with bit 8 set clears the flag and all captured fields. Bit 8 reads as zero, and the other bits written to index 1 are ignored.
- R8: If an acknowledge and a strobe fall in the same cycle, the new error is captured and the flag stays set.
- R9: `irq_o` is registered and equals (controller interrupt AND interrupt enable) OR (parity flag AND parity interrupt enable), evaluated on the state one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 2 | Register index (0 status, 1 parity control, 2 low address) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data for the selected index |
| ctl_irq_i | input | 1 | Interrupt request from the network controller |
| strap_base_i | input | 4 | Strapped RAM base-address bits |
| perr_stb_i | input | 1 | One-cycle parity error strobe |
| perr_src_i | input | 1 | Source of the failing access |
| perr_lane_i | input | 1 | Failing byte lane |
| perr_addr_i | input | 20 | Failing memory address |
| ctl_reset_o | output | 1 | Controller reset |
| ctl_attn_o | output | 1 | Controller channel attention |
| on_air_o | output | 1 | High to leave loopback |
| xbus_en_o | output | 1 | Expansion bus enable |
| big_ram_o | output | 1 | Large RAM select |
| irq_o | output | 1 | Combined interrupt to the host |

## Verification
The block is tried with three kinds of stimulus: host writes of single control bits and of all ones, changes in the level of the controller interrupt, and parity strobes carrying distinct address, source and lane values. Writing all ones separates the writable bits from the read-only ones. Two different error records, one strobed while the flag is already set and one after an acknowledge, distinguish a frozen capture from an overwritten one. Toggling each interrupt enable against each source checks that the two terms of the interrupt are combined correctly. Directed tests cover the reset state, a reset during operation, and an acknowledge that coincides with a strobe.

// File: rtl/brdctl_pkg.sv
package brdctl_pkg;
  localparam int WORD_W = 16;
  localparam int SEL_W  = 2;

  // status word positions
  localparam int ST_RESET = 15;
  localparam int ST_ONAIR = 14;
  localparam int ST_ATTN  = 13;
  localparam int ST_IEN   = 12;
  localparam int ST_PIEN  = 11;
  localparam int ST_PFLAG = 9;
  localparam int ST_IFLAG = 8;
  localparam int ST_XBUS  = 5;
  localparam int ST_BIG   = 4;

  // parity control positions
  localparam int PC_ACK  = 8;
  localparam int PC_SRC  = 7;
  localparam int PC_LANE = 6;

  localparam logic [SEL_W-1:0] SEL_STATUS = 2'd0;
  localparam logic [SEL_W-1:0] SEL_PCTL   = 2'd1;
  localparam logic [SEL_W-1:0] SEL_ALO    = 2'd2;

  typedef struct packed {
    logic reset;
    logic onair;
    logic attn;
    logic ien;
    logic pien;
    logic xbus;
    logic big;
  } ctl_bits_t;
endpackage

// File: rtl/brdctl_ctrl_reg.sv
module brdctl_ctrl_reg
  import brdctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_en,
  input  ctl_bits_t wr_bits,
  output ctl_bits_t ctl_q
);
  always_ff @(posedge clk) begin
    if (rst)        ctl_q <= '0;
    else if (wr_en) ctl_q <= wr_bits;
  end

  // attention line must match the value last written
  assert_attn_follows_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (ctl_q.attn == $past(wr_bits.attn)));

  // without a write, control state holds
  assert_ctl_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(ctl_q));
endmodule

// File: rtl/brdctl_perr_cap.sv
module brdctl_perr_cap #(
  parameter int ADDR_W = 20,
  parameter int LO_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb_i,
  input  logic              src_i,
  input  logic              lane_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ack_i,
  output logic              flag_q,
  output logic              src_q,
  output logic              lane_q,
  output logic [ADDR_W-1:0] addr_q
);
  logic take;
  assign take = stb_i && (!flag_q || ack_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      src_q  <= 1'b0;
      lane_q <= 1'b0;
      addr_q <= '0;
    end else if (take) begin
      flag_q <= 1'b1;
      src_q  <= src_i;
      lane_q <= lane_i;
      addr_q <= addr_i;
    end else if (ack_i) begin
      flag_q <= 1'b0;
      src_q  <= 1'b0;
      lane_q <= 1'b0;
      addr_q <= '0;
    end
  end

  assert_strobe_sets_R5: assert property (@(posedge clk) disable iff (rst)
    stb_i |=> flag_q);

  assert_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !ack_i) |=> (flag_q && $stable(addr_q) && $stable(src_q) && $stable(lane_q)));

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !stb_i) |=> (!flag_q && addr_q == '0));

  assert_ack_race_R8: assert property (@(posedge clk) disable iff (rst)
    (ack_i && stb_i) |=> (flag_q && addr_q == $past(addr_i)));
endmodule

// File: rtl/brdctl_top.sv
module brdctl_top
  import brdctl_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LO_W   = 16,
  parameter int BASE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [1:0]        host_sel,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  input  logic              ctl_irq_i,
  input  logic [BASE_W-1:0] strap_base_i,
  input  logic              perr_stb_i,
  input  logic              perr_src_i,
  input  logic              perr_lane_i,
  input  logic [ADDR_W-1:0] perr_addr_i,
  output logic              ctl_reset_o,
  output logic              ctl_attn_o,
  output logic              on_air_o,
  output logic              xbus_en_o,
  output logic              big_ram_o,
  output logic              irq_o
);
  localparam int HI_W = ADDR_W - LO_W;

  ctl_bits_t ctl_q, wr_bits;
  logic      wr_status, wr_ack;
  logic      pflag, psrc, plane;
  logic [ADDR_W-1:0] paddr;

  assign wr_status = host_wr && (host_sel == SEL_STATUS);
  assign wr_ack    = host_wr && (host_sel == SEL_PCTL) && host_wdata[PC_ACK];

  assign wr_bits.reset = host_wdata[ST_RESET];
  assign wr_bits.onair = host_wdata[ST_ONAIR];
  assign wr_bits.attn  = host_wdata[ST_ATTN];
  assign wr_bits.ien   = host_wdata[ST_IEN];
  assign wr_bits.pien  = host_wdata[ST_PIEN];
  assign wr_bits.xbus  = host_wdata[ST_XBUS];
  assign wr_bits.big   = host_wdata[ST_BIG];

  logic unused_wbits;
  assign unused_wbits = ^{host_wdata[10], host_wdata[7:6], host_wdata[3:0]};

  brdctl_ctrl_reg u_ctl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_status),
    .wr_bits (wr_bits),
    .ctl_q   (ctl_q)
  );

  brdctl_perr_cap #(.ADDR_W(ADDR_W), .LO_W(LO_W)) u_perr (
    .clk    (clk),
    .rst    (rst),
    .stb_i  (perr_stb_i),
    .src_i  (perr_src_i),
    .lane_i (perr_lane_i),
    .addr_i (perr_addr_i),
    .ack_i  (wr_ack),
    .flag_q (pflag),
    .src_q  (psrc),
    .lane_q (plane),
    .addr_q (paddr)
  );

  assign ctl_reset_o = ctl_q.reset;
  assign ctl_attn_o  = ctl_q.attn;
  assign on_air_o    = ctl_q.onair;
  assign xbus_en_o   = ctl_q.xbus;
  assign big_ram_o   = ctl_q.big;

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= (ctl_irq_i && ctl_q.ien) || (pflag && ctl_q.pien);
  end

  logic [15:0] stat_word, pctl_word;
  always_comb begin
    stat_word = '0;
    stat_word[ST_RESET] = ctl_q.reset;
    stat_word[ST_ONAIR] = ctl_q.onair;
    stat_word[ST_ATTN]  = ctl_q.attn;
    stat_word[ST_IEN]   = ctl_q.ien;
    stat_word[ST_PIEN]  = ctl_q.pien;
    stat_word[ST_PFLAG] = pflag;
    stat_word[ST_IFLAG] = ctl_irq_i;
    stat_word[ST_XBUS]  = ctl_q.xbus;
    stat_word[ST_BIG]   = ctl_q.big;
    stat_word[BASE_W-1:0] = strap_base_i;

    pctl_word = '0;
    pctl_word[PC_SRC]  = psrc;
    pctl_word[PC_LANE] = plane;
    pctl_word[HI_W-1:0] = paddr[ADDR_W-1:LO_W];
  end

  always_comb begin
    case (host_sel)
      SEL_STATUS: host_rdata = stat_word;
      SEL_PCTL:   host_rdata = pctl_word;
      SEL_ALO:    host_rdata = paddr[LO_W-1:0];
      default:    host_rdata = '0;
    endcase
  end

  // both enables off: no interrupt one cycle later
  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q.ien && !ctl_q.pien) |=> !irq_o);

  // parity term alone must raise the line
  assert_irq_parity_R9: assert property (@(posedge clk) disable iff (rst)
    (pflag && ctl_q.pien) |=> irq_o);
endmodule

// File: tb/brdctl_top_tb_top.sv
module brdctl_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  logic host_wr;
  logic [1:0] host_sel;
  logic [15:0] host_wdata, host_rdata;
  logic ctl_irq_i;
  logic [3:0] strap_base_i;
  logic perr_stb_i, perr_src_i, perr_lane_i;
  logic [19:0] perr_addr_i;
  logic ctl_reset_o, ctl_attn_o, on_air_o, xbus_en_o, big_ram_o, irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brdctl_top dut_i (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .ctl_irq_i(ctl_irq_i),
    .strap_base_i(strap_base_i), .perr_stb_i(perr_stb_i), .perr_src_i(perr_src_i),
    .perr_lane_i(perr_lane_i), .perr_addr_i(perr_addr_i), .ctl_reset_o(ctl_reset_o),
    .ctl_attn_o(ctl_attn_o), .on_air_o(on_air_o), .xbus_en_o(xbus_en_o),
    .big_ram_o(big_ram_o), .irq_o(irq_o)
  );

  // kind: 0 host write, 1 parity strobe, 2 interrupt level only
  // strobe data: [21] source, [20] lane, [19:0] address
  typedef struct packed {
    logic [1:0]  kind;
    logic [1:0]  sel;
    logic [23:0] data;
    logic        irq_lvl;
    logic [15:0] e_stat;
    logic [15:0] e_pctl;
    logic [15:0] e_lo;
    logic        e_irq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 2'd0, 24'h004000, 1'b0, 16'h4005, 16'h0000, 16'h0000, 1'b0}, // R2 on-air
    '{2'd0, 2'd0, 24'h006000, 1'b0, 16'h6005, 16'h0000, 16'h0000, 1'b0}, // R3 attention set
    '{2'd0, 2'd0, 24'h004000, 1'b0, 16'h4005, 16'h0000, 16'h0000, 1'b0}, // R3 attention cleared
    '{2'd2, 2'd0, 24'h000000, 1'b1, 16'h4105, 16'h0000, 16'h0000, 1'b0}, // R4 R9 flag seen, enable off
    '{2'd0, 2'd0, 24'h005000, 1'b1, 16'h5105, 16'h0000, 16'h0000, 1'b1}, // R9 controller term
    '{2'd2, 2'd0, 24'h000000, 1'b0, 16'h5005, 16'h0000, 16'h0000, 1'b0}, // R9 source drops
    '{2'd1, 2'd0, 24'h2A1234, 1'b0, 16'h5205, 16'h008A, 16'h1234, 1'b0}, // R5 capture
    '{2'd0, 2'd0, 24'h005800, 1'b0, 16'h5A05, 16'h008A, 16'h1234, 1'b1}, // R9 parity term
    '{2'd1, 2'd0, 24'h13BEEF, 1'b0, 16'h5A05, 16'h008A, 16'h1234, 1'b1}, // R6 frozen
    '{2'd0, 2'd1, 24'h000100, 1'b0, 16'h5805, 16'h0000, 16'h0000, 1'b0}, // R7 ack
    '{2'd1, 2'd0, 24'h13BEEF, 1'b0, 16'h5A05, 16'h0043, 16'hBEEF, 1'b1}, // R5 second capture
    '{2'd0, 2'd1, 24'h0000FF, 1'b0, 16'h5A05, 16'h0043, 16'hBEEF, 1'b1}, // R7 non-ack bits ignored
    '{2'd0, 2'd0, 24'h00FFFF, 1'b0, 16'hFA35, 16'h0043, 16'hBEEF, 1'b1}, // R2 R4 all ones
    '{2'd0, 2'd0, 24'h000000, 1'b0, 16'h0205, 16'h0043, 16'hBEEF, 1'b0}, // R2 R9 all cleared
    '{2'd0, 2'd1, 24'h000100, 1'b0, 16'h0005, 16'h0000, 16'h0000, 1'b0}  // R7 final ack
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output logic [15:0] v);
    host_sel = s;
    #1;
    v = host_rdata;
  endtask

  task automatic check_all(input string tag, input logic [15:0] es, input logic [15:0] ep,
                           input logic [15:0] el, input logic ei);
    logic [15:0] v;
    rd(2'd0, v); chk({tag, " status"}, v, es);
    rd(2'd1, v); chk({tag, " pctl"}, v, ep);
    rd(2'd2, v); chk({tag, " addr-lo"}, v, el);
    rd(2'd3, v); chk({tag, " idx3"}, v, 16'h0000);
    chk({tag, " irq_o"}, {15'd0, irq_o}, {15'd0, ei});
    chk({tag, " outputs"}, {11'd0, ctl_reset_o, on_air_o, ctl_attn_o, xbus_en_o, big_ram_o},
        {11'd0, es[15], es[14], es[13], es[5], es[4]});
  endtask

  task automatic settle2();
    @(posedge clk); @(negedge clk);
    host_wr = 1'b0; perr_stb_i = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; host_wr = 1'b0; host_sel = '0; host_wdata = '0;
    ctl_irq_i = 1'b0; strap_base_i = 4'h5; perr_stb_i = 1'b0;
    perr_src_i = 1'b0; perr_lane_i = 1'b0; perr_addr_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check_all("R1 reset", 16'h0005, 16'h0000, 16'h0000, 1'b0);

    for (int i = 0; i < NV; i++) begin
      ctl_irq_i = VEC[i].irq_lvl;
      if (VEC[i].kind == 2'd0) begin
        host_wr = 1'b1; host_sel = VEC[i].sel; host_wdata = VEC[i].data[15:0];
      end else if (VEC[i].kind == 2'd1) begin
        perr_stb_i = 1'b1; perr_src_i = VEC[i].data[21];
        perr_lane_i = VEC[i].data[20]; perr_addr_i = VEC[i].data[19:0];
      end
      settle2();
      check_all($sformatf("vector %0d R2/R3/R4/R5/R6/R7/R9", i),
                VEC[i].e_stat, VEC[i].e_pctl, VEC[i].e_lo, VEC[i].e_irq);
    end

    // R8: ack and strobe together while an error is held
    perr_stb_i = 1'b1; perr_src_i = 1'b1; perr_lane_i = 1'b1; perr_addr_i = 20'h71111;
    settle2();
    host_wr = 1'b1; host_sel = 2'd1; host_wdata = 16'h0100;
    perr_stb_i = 1'b1; perr_src_i = 1'b0; perr_lane_i = 1'b1; perr_addr_i = 20'h92222;
    settle2();
    check_all("R8 ack+strobe", 16'h0205, 16'h0049, 16'h2222, 1'b0);

    // R1: reset in the middle of operation
    host_wr = 1'b1; host_sel = 2'd0; host_wdata = 16'hF830;
    settle2();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk); rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check_all("R1 mid-run reset", 16'h0005, 16'h0000, 16'h0000, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule